// File: doc/BRIEF.md
# Block Transfer Byte Packer

This block moves payload between a buffer whose entries are 16 bits wide and a card data port that carries one byte at a time. It serves multi-block transfers. In the receive direction it assembles bytes from the card into buffer entries. In the transmit direction it splits buffer entries back into bytes. The low byte of an entry always travels first.

Two down-counters track the transfer: one for the bytes left in the current block and one for the blocks left in the transfer. When a block ends, the byte counter reloads from the programmed length. A block of odd length therefore closes with a half-filled entry, and the next block starts on a fresh entry. When the last block ends, the block counter reloads, the transfer-active flag drops and a one-cycle done pulse is raised. The controller uses that pulse to set its transfer-done status bit.

The card side uses a request/ready handshake, so at most one byte moves per clock. The buffer side uses push and pop strobes, gated by the occupancy count the buffer reports. Software programs the length and count while the block is idle. A new data command or a controller disable throws away any partly built entry.

Top module: `blk_byte_packer`

## Requirements
- R1: After reset the block is idle. No card request and no push or pop is raised while it is idle. Both live counters read 1.
- R2: A length write with value v sets the block length to v+1 and loads the byte counter with v+1. A count write with value v sets the block count to v+1 and loads the block counter with v+1. A count write also reloads the byte counter from the block length. If both writes happen in the same cycle, the new length is used. The live counters are visible on bytes_left and blocks_left.
- R3: Receive (cmd_dir=1). The first byte of an entry goes to bits 7:0. If the block still has bytes left, the next byte goes to bits 15:8 and the entry is pushed in that byte's cycle. If the first byte was the block's last byte, the entry is pushed in that same cycle with bits 15:8 set to zero.
- R4: Transmit (cmd_dir=0). The block sends bits 7:0 of the head entry. If the block still has bytes left, it then sends bits 15:8. The entry is popped in the cycle its final byte is accepted.
- R5: A new receive entry is not started while buf_count is greater than af_level. The high byte of an entry already begun is not held back.
- R6: A new transmit entry is not started while buf_count is 0.
- R7: A byte moves only in a cycle where a card request and card_rdy are both high. While card_rdy is low, the counters hold and the request stays raised.
- R8: Each accepted byte lowers bytes_left by one. When the block's last byte is accepted, bytes_left reloads to the block length and blocks_left drops by one.
- R9: When the last byte of the last block is accepted, xfer_active falls on the next cycle. In that same cycle xfer_done is high for exactly one cycle, and both counters read their programmed values again.
- R10: With enable low, xfer_active clears on the next edge and both counters reload. cmd_start with enable high restarts the transfer and reloads both counters. Either event drops any partly built entry, including a byte accepted in that same cycle.
- R11: Length and count writes made while a transfer is active have no effect.
- R12: Card read and write requests are never raised together. Push and pop are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; low aborts the transfer |
| cmd_start | input | 1 | Data command issued; starts or restarts a transfer |
| cmd_dir | input | 1 | Direction for the command: 1 receive, 0 transmit |
| len_wr | input | 1 | Block length write strobe |
| len_val | input | 11 | Block length minus one |
| cnt_wr | input | 1 | Block count write strobe |
| cnt_val | input | 11 | Block count minus one |
| af_level | input | 5 | Almost-full level for receive pausing |
| buf_count | input | 6 | Current buffer occupancy in entries |
| buf_rdata | input | 16 | Head entry of the buffer |
| buf_push | output | 1 | Push buf_wdata into the buffer |
| buf_wdata | output | 16 | Assembled receive entry |
| buf_pop | output | 1 | Pop the head entry |
| card_rdy | input | 1 | Card port accepts or supplies a byte this cycle |
| card_rd_data | input | 8 | Byte from the card |
| card_rd_req | output | 1 | Request a byte from the card |
| card_wr_req | output | 1 | Offer card_wr_data to the card |
| card_wr_data | output | 8 | Byte toward the card |
| bytes_left | output | 12 | Live byte counter of the current block |
| blocks_left | output | 12 | Live block counter of the transfer |
| xfer_active | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
A packing phase that gets out of step with the byte counter shows up at once. Either a pushed entry carries a byte in the wrong half, or a non-zero upper half appears where a block of odd length should have left zeros. The mismatch reaches buf_wdata or card_wr_data in the very cycle the entry closes. A counter that reloads or decrements wrongly shifts the block boundaries, so the wrong entry gets the zeroed upper half within one block. It also moves the done pulse away from the total byte count predicted from length times count. The sweep covers lengths 1 to 5, counts 1 to 3, both directions, and steady or stuttering card readiness. Every cut between entries and blocks in that range is therefore compared against arithmetic expectations.

// File: rtl/bpk_pkg.sv
package bpk_pkg;

    localparam int LEN_W = 11;
    localparam int CTR_W = LEN_W + 1;
    localparam int LVL_W = 5;
    localparam int OCC_W = LVL_W + 1;
    localparam int BYTE_W = 8;
    localparam int ENTRY_W = 2 * BYTE_W;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } xfer_dir_t;

    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } pack_phase_t;

    typedef struct packed {
        logic [CTR_W-1:0] blk_len;
        logic [CTR_W-1:0] blk_cnt;
    } xfer_cfg_t;

    typedef struct packed {
        logic                rd_req;
        logic                wr_req;
        logic [BYTE_W-1:0]   wr_byte;
        logic                push;
        logic                pop;
        logic [ENTRY_W-1:0]  entry;
    } lane_out_t;

    function automatic logic [CTR_W-1:0] widen_plus_one(input logic [LEN_W-1:0] v);
        return {1'b0, v} + CTR_W'(1);
    endfunction

endpackage

// File: rtl/bpk_down_ctr.sv
module bpk_down_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] value,
    output logic         at_one
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= W'(1);
        end else if (load) begin
            value <= load_val;
        end else if (dec) begin
            value <= value - W'(1);
        end
    end

    assign at_one = (value == W'(1));
endmodule

// File: rtl/bpk_counters.sv
module bpk_counters
    import bpk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_val,
    input  logic             cnt_wr,
    input  logic [LEN_W-1:0] cnt_val,
    input  logic             byte_acc,
    output logic             last_byte,
    output logic [CTR_W-1:0] bytes_left,
    output logic [CTR_W-1:0] blocks_left,
    output logic             active,
    output logic             done
);
    localparam int NCTR = 2;
    localparam int IDX_BYTE = 0;
    localparam int IDX_BLK = 1;

    xfer_cfg_t        cfg_q;
    logic [CTR_W-1:0] len_new, cnt_new;
    logic             idle_wr_ok;

    logic [NCTR-1:0]  c_load, c_dec, c_one;
    logic [CTR_W-1:0] c_val  [NCTR];
    logic [CTR_W-1:0] c_ldv  [NCTR];

    assign len_new    = widen_plus_one(len_val);
    assign cnt_new    = widen_plus_one(cnt_val);
    assign idle_wr_ok = !active && !abort && !start;

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        bpk_down_ctr #(.W(CTR_W)) u_ctr (
            .clk      (clk),
            .rst      (rst),
            .load     (c_load[g]),
            .load_val (c_ldv[g]),
            .dec      (c_dec[g]),
            .value    (c_val[g]),
            .at_one   (c_one[g])
        );
    end

    always_comb begin
        c_load = '0;
        c_dec  = '0;
        c_ldv[IDX_BYTE] = cfg_q.blk_len;
        c_ldv[IDX_BLK]  = cfg_q.blk_cnt;
        if (abort || start) begin
            c_load = '1;
        end else if (active) begin
            if (byte_acc) begin
                if (c_one[IDX_BYTE]) begin
                    c_load[IDX_BYTE] = 1'b1;
                    if (c_one[IDX_BLK]) c_load[IDX_BLK] = 1'b1;
                    else                c_dec[IDX_BLK]  = 1'b1;
                end else begin
                    c_dec[IDX_BYTE] = 1'b1;
                end
            end
        end else begin
            if (len_wr) begin
                c_load[IDX_BYTE] = 1'b1;
                c_ldv[IDX_BYTE]  = len_new;
            end
            if (cnt_wr) begin
                c_load[IDX_BLK]  = 1'b1;
                c_ldv[IDX_BLK]   = cnt_new;
                c_load[IDX_BYTE] = 1'b1;
                c_ldv[IDX_BYTE]  = len_wr ? len_new : cfg_q.blk_len;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.blk_len <= CTR_W'(1);
            cfg_q.blk_cnt <= CTR_W'(1);
            active        <= 1'b0;
            done          <= 1'b0;
        end else begin
            done <= 1'b0;
            if (idle_wr_ok && len_wr) cfg_q.blk_len <= len_new;
            if (idle_wr_ok && cnt_wr) cfg_q.blk_cnt <= cnt_new;
            if (abort) begin
                active <= 1'b0;
            end else if (start) begin
                active <= 1'b1;
            end else if (active && byte_acc && c_one[IDX_BYTE] && c_one[IDX_BLK]) begin
                active <= 1'b0;
                done   <= 1'b1;
            end
        end
    end

    assign last_byte   = c_one[IDX_BYTE];
    assign bytes_left  = c_val[IDX_BYTE];
    assign blocks_left = c_val[IDX_BLK];
endmodule

// File: rtl/bpk_lane.sv
module bpk_lane
    import bpk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               abort,
    input  logic               start_dir,
    input  logic               active,
    input  logic               last_byte,
    input  logic [LVL_W-1:0]   af_level,
    input  logic [OCC_W-1:0]   buf_count,
    input  logic [ENTRY_W-1:0] buf_rdata,
    input  logic               card_rdy,
    input  logic [BYTE_W-1:0]  card_rd_data,
    output lane_out_t          lo,
    output logic               byte_acc
);
    pack_phase_t       phase_q;
    xfer_dir_t         dir_q;
    logic [BYTE_W-1:0] hold_q;
    logic              room_ok, want, entry_close;

    always_comb begin
        if (dir_q == DIR_RX) room_ok = (buf_count <= OCC_W'(af_level));
        else                 room_ok = (buf_count != '0);
    end

    assign want        = active && ((phase_q == PH_HI) || room_ok);
    assign byte_acc    = want && card_rdy;
    assign entry_close = byte_acc && ((phase_q == PH_HI) || last_byte);

    always_comb begin
        lo.rd_req  = want && (dir_q == DIR_RX);
        lo.wr_req  = want && (dir_q == DIR_TX);
        lo.wr_byte = (phase_q == PH_HI) ? buf_rdata[ENTRY_W-1:BYTE_W]
                                        : buf_rdata[BYTE_W-1:0];
        lo.push    = entry_close && (dir_q == DIR_RX);
        lo.pop     = entry_close && (dir_q == DIR_TX);
        lo.entry   = (phase_q == PH_HI) ? {card_rd_data, hold_q}
                                        : {{BYTE_W{1'b0}}, card_rd_data};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_LO;
            dir_q   <= DIR_TX;
            hold_q  <= '0;
        end else if (abort) begin
            phase_q <= PH_LO;
        end else if (start) begin
            phase_q <= PH_LO;
            dir_q   <= xfer_dir_t'(start_dir);
        end else if (byte_acc) begin
            if (phase_q == PH_LO) hold_q <= card_rd_data;
            phase_q <= entry_close ? PH_LO : PH_HI;
        end
    end
endmodule

// File: rtl/blk_byte_packer.sv
module blk_byte_packer
    import bpk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               cmd_start,
    input  logic               cmd_dir,
    input  logic               len_wr,
    input  logic [LEN_W-1:0]   len_val,
    input  logic               cnt_wr,
    input  logic [LEN_W-1:0]   cnt_val,
    input  logic [LVL_W-1:0]   af_level,
    input  logic [OCC_W-1:0]   buf_count,
    input  logic [ENTRY_W-1:0] buf_rdata,
    output logic               buf_push,
    output logic [ENTRY_W-1:0] buf_wdata,
    output logic               buf_pop,
    input  logic               card_rdy,
    input  logic [BYTE_W-1:0]  card_rd_data,
    output logic               card_rd_req,
    output logic               card_wr_req,
    output logic [BYTE_W-1:0]  card_wr_data,
    output logic [CTR_W-1:0]   bytes_left,
    output logic [CTR_W-1:0]   blocks_left,
    output logic               xfer_active,
    output logic               xfer_done
);
    logic      abort, start, byte_acc, last_byte;
    lane_out_t lane;

    assign abort = !enable;
    assign start = cmd_start && enable;

    bpk_counters u_ctrs (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .abort       (abort),
        .len_wr      (len_wr),
        .len_val     (len_val),
        .cnt_wr      (cnt_wr),
        .cnt_val     (cnt_val),
        .byte_acc    (byte_acc),
        .last_byte   (last_byte),
        .bytes_left  (bytes_left),
        .blocks_left (blocks_left),
        .active      (xfer_active),
        .done        (xfer_done)
    );

    bpk_lane u_lane (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .abort        (abort),
        .start_dir    (cmd_dir),
        .active       (xfer_active),
        .last_byte    (last_byte),
        .af_level     (af_level),
        .buf_count    (buf_count),
        .buf_rdata    (buf_rdata),
        .card_rdy     (card_rdy),
        .card_rd_data (card_rd_data),
        .lo           (lane),
        .byte_acc     (byte_acc)
    );

    assign card_rd_req  = lane.rd_req;
    assign card_wr_req  = lane.wr_req;
    assign card_wr_data = lane.wr_byte;
    assign buf_push     = lane.push;
    assign buf_pop      = lane.pop;
    assign buf_wdata    = lane.entry;
endmodule

// File: rtl/bpk_checker.sv
module bpk_checker
    import bpk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             cmd_start,
    input logic             len_wr,
    input logic [LVL_W-1:0] af_level,
    input logic [OCC_W-1:0] buf_count,
    input logic             buf_push,
    input logic             buf_pop,
    input logic             card_rdy,
    input logic             card_rd_req,
    input logic             card_wr_req,
    input logic [CTR_W-1:0] bytes_left,
    input logic             xfer_active,
    input logic             xfer_done
);
    logic acc, mid_q;

    assign acc = (card_rd_req || card_wr_req) && card_rdy;

    // Entry-in-progress tracker rebuilt from port activity only
    always_ff @(posedge clk) begin
        if (rst || !enable || cmd_start) mid_q <= 1'b0;
        else if (buf_push || buf_pop)    mid_q <= 1'b0;
        else if (acc)                    mid_q <= 1'b1;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !xfer_active |-> !card_rd_req && !card_wr_req && !buf_push && !buf_pop);

    assert_rx_pause_R5: assert property (@(posedge clk) disable iff (rst)
        !mid_q && (buf_count > OCC_W'(af_level)) |-> !card_rd_req);

    assert_tx_pause_R6: assert property (@(posedge clk) disable iff (rst)
        !mid_q && (buf_count == '0) |-> !card_wr_req);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
        xfer_active && (card_rd_req || card_wr_req) && !card_rdy && enable && !cmd_start
        |=> $stable(bytes_left));

    assert_byte_dec_R8: assert property (@(posedge clk) disable iff (rst)
        xfer_active && acc && enable && !cmd_start && (bytes_left != CTR_W'(1))
        |=> bytes_left == $past(bytes_left) - CTR_W'(1));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> !xfer_active && $past(xfer_active));

    assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !xfer_active);

    assert_busy_write_R11: assert property (@(posedge clk) disable iff (rst)
        xfer_active && len_wr && !acc && enable && !cmd_start |=> $stable(bytes_left));

    assert_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(card_rd_req && card_wr_req) && !(buf_push && buf_pop));
endmodule

bind blk_byte_packer bpk_checker u_bpk_checker (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .cmd_start   (cmd_start),
    .len_wr      (len_wr),
    .af_level    (af_level),
    .buf_count   (buf_count),
    .buf_push    (buf_push),
    .buf_pop     (buf_pop),
    .card_rdy    (card_rdy),
    .card_rd_req (card_rd_req),
    .card_wr_req (card_wr_req),
    .bytes_left  (bytes_left),
    .xfer_active (xfer_active),
    .xfer_done   (xfer_done)
);

// File: tb/tb_blk_byte_packer.sv
module tb_blk_byte_packer;
    logic        clk = 1'b0;
    logic        rst, enable, cmd_start, cmd_dir, len_wr, cnt_wr, card_rdy;
    logic [10:0] len_val, cnt_val;
    logic [4:0]  af_level;
    logic [5:0]  buf_count;
    logic [15:0] buf_rdata, buf_wdata;
    logic [7:0]  card_rd_data, card_wr_data;
    logic        buf_push, buf_pop, card_rd_req, card_wr_req, xfer_active, xfer_done;
    logic [11:0] bytes_left, blocks_left;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    blk_byte_packer dut (
        .clk(clk), .rst(rst), .enable(enable), .cmd_start(cmd_start), .cmd_dir(cmd_dir),
        .len_wr(len_wr), .len_val(len_val), .cnt_wr(cnt_wr), .cnt_val(cnt_val),
        .af_level(af_level), .buf_count(buf_count), .buf_rdata(buf_rdata),
        .buf_push(buf_push), .buf_wdata(buf_wdata), .buf_pop(buf_pop),
        .card_rdy(card_rdy), .card_rd_data(card_rd_data), .card_rd_req(card_rd_req),
        .card_wr_req(card_wr_req), .card_wr_data(card_wr_data),
        .bytes_left(bytes_left), .blocks_left(blocks_left),
        .xfer_active(xfer_active), .xfer_done(xfer_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rx_byte(input int k);
        return (k * 7 + 3) % 256;
    endfunction

    function automatic logic [15:0] tx_entry(input int e);
        return {8'((e * 13 + 5) % 256), 8'((e * 29 + 1) % 256)};
    endfunction

    task automatic cfg(input int len, input int cnt);
        @(negedge clk);
        len_wr = 1'b1; len_val = 11'(len - 1);
        cnt_wr = 1'b1; cnt_val = 11'(cnt - 1);
        @(negedge clk);
        len_wr = 1'b0; cnt_wr = 1'b0;
        #1;
        check(bytes_left == 12'(len), "R2 length", int'(bytes_left), len);
        check(blocks_left == 12'(cnt), "R2 count", int'(blocks_left), cnt);
    endtask

    task automatic issue(input bit dir);
        @(negedge clk);
        cmd_start = 1'b1; cmd_dir = dir;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic finish_checks(input int len, input int cnt, input int dones);
        check(dones == 1, "R9 done count", dones, 1);
        check(!xfer_active, "R9 active clear", int'(xfer_active), 0);
        check(bytes_left == 12'(len) && blocks_left == 12'(cnt), "R9 reload",
              int'(bytes_left) * 4096 + int'(blocks_left), len * 4096 + cnt);
        @(negedge clk); #1;
        check(!xfer_done, "R9 one-cycle pulse", int'(xfer_done), 0);
    endtask

    task automatic run_rx(input int len, input int cnt, input int mode);
        int idx = 0, e = 0, dones = 0, guard = 0, prev_bl = 0;
        int epb = (len + 1) / 2;
        bit stall = 1'b0;
        issue(1'b1);
        while (dones == 0 && guard < 4000) begin
            card_rdy = (mode == 0) ? 1'b1 : ((guard % 3) != 2);
            card_rd_data = 8'(rx_byte(idx));
            #1;
            if (stall)
                check(card_rd_req && bytes_left == 12'(prev_bl), "R7 stall", int'(bytes_left), prev_bl);
            stall = card_rd_req && !card_rdy;
            prev_bl = int'(bytes_left);
            check(!(card_rd_req && card_wr_req) && !(buf_push && buf_pop), "R12", 1, 0);
            if (buf_push) begin
                int blk = e / epb;
                int j = (e % epb) * 2;
                int k = blk * len + j;
                int hi = (j + 1 < len) ? rx_byte(k + 1) : 0;
                int exp = hi * 256 + rx_byte(k);
                check(buf_wdata == 16'(exp), "R3 entry", int'(buf_wdata), exp);
                e++;
            end
            if (card_rd_req && card_rdy) idx++;
            if (xfer_done) dones++;
            guard++;
            if (dones == 0) @(negedge clk);
        end
        card_rdy = 1'b0;
        check(e == cnt * epb, "R3 push count", e, cnt * epb);
        check(idx == len * cnt, "R8 byte total", idx, len * cnt);
        finish_checks(len, cnt, dones);
    endtask

    task automatic run_tx(input int len, input int cnt, input int mode);
        int head = 0, k = 0, dones = 0, guard = 0, prev_bl = 0;
        int epb = (len + 1) / 2;
        int total = cnt * epb;
        bit stall = 1'b0;
        issue(1'b0);
        while (dones == 0 && guard < 4000) begin
            card_rdy = (mode == 0) ? 1'b1 : ((guard % 3) != 2);
            buf_count = 6'((total - head > 31) ? 31 : total - head);
            buf_rdata = tx_entry(head);
            #1;
            if (stall)
                check(card_wr_req && bytes_left == 12'(prev_bl), "R7 stall", int'(bytes_left), prev_bl);
            stall = card_wr_req && !card_rdy;
            prev_bl = int'(bytes_left);
            check(!(card_rd_req && card_wr_req) && !(buf_push && buf_pop), "R12", 1, 0);
            if (card_wr_req && card_rdy) begin
                int blk = k / len;
                int j = k % len;
                logic [15:0] ent = tx_entry(blk * epb + j / 2);
                int exp = (j % 2 == 1) ? int'(ent[15:8]) : int'(ent[7:0]);
                check(card_wr_data == 8'(exp), "R4 byte", int'(card_wr_data), exp);
                k++;
            end
            if (buf_pop) head++;
            if (xfer_done) dones++;
            guard++;
            if (dones == 0) @(negedge clk);
        end
        card_rdy = 1'b0;
        buf_count = '0;
        check(head == total, "R4 pop count", head, total);
        check(k == len * cnt, "R8 byte total", k, len * cnt);
        finish_checks(len, cnt, dones);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; enable = 1'b1; cmd_start = 1'b0; cmd_dir = 1'b0;
        len_wr = 1'b0; cnt_wr = 1'b0; len_val = '0; cnt_val = '0;
        af_level = 5'd31; buf_count = '0; buf_rdata = '0;
        card_rdy = 1'b0; card_rd_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(!xfer_active && !xfer_done, "R1 idle", int'(xfer_active), 0);
        check(!card_rd_req && !card_wr_req && !buf_push && !buf_pop, "R1 quiet", 1, 0);
        check(bytes_left == 12'd1 && blocks_left == 12'd1, "R1 counters",
              int'(bytes_left) * 4096 + int'(blocks_left), 4097);

        // R2 separate writes: length write loads the byte counter
        cfg(10, 3);
        @(negedge clk); len_wr = 1'b1; len_val = 11'd3;
        @(negedge clk); len_wr = 1'b0; #1;
        check(bytes_left == 12'd4 && blocks_left == 12'd3, "R2 length only",
              int'(bytes_left) * 4096 + int'(blocks_left), 4 * 4096 + 3);
        // R2 count write reloads the byte counter from the stored length
        @(negedge clk); cnt_wr = 1'b1; cnt_val = 11'd0;
        @(negedge clk); cnt_wr = 1'b0; #1;
        check(bytes_left == 12'd4 && blocks_left == 12'd1, "R2 count reload",
              int'(bytes_left) * 4096 + int'(blocks_left), 4 * 4096 + 1);

        // R3 R4 R7 R8 R9 sweep
        for (int len = 1; len <= 5; len++)
            for (int cnt = 1; cnt <= 3; cnt++)
                for (int mode = 0; mode < 2; mode++) begin
                    cfg(len, cnt);
                    run_rx(len, cnt, mode);
                    cfg(len, cnt);
                    run_tx(len, cnt, mode);
                end

        // R5 receive pause above almost-full level
        cfg(2, 1);
        af_level = 5'd4; buf_count = 6'd5; card_rdy = 1'b0;
        issue(1'b1);
        for (int i = 0; i < 4; i++) begin
            #1 check(!card_rd_req, "R5 paused", int'(card_rd_req), 0);
            @(negedge clk);
        end
        buf_count = 6'd4; #1;
        check(card_rd_req, "R5 resumes at level", int'(card_rd_req), 1);
        @(negedge clk); enable = 1'b0;
        @(negedge clk); enable = 1'b1; buf_count = '0; af_level = 5'd31; #1;
        check(!xfer_active, "R10 disable", int'(xfer_active), 0);

        // R6 transmit pause on empty buffer
        issue(1'b0);
        for (int i = 0; i < 4; i++) begin
            #1 check(!card_wr_req, "R6 paused", int'(card_wr_req), 0);
            @(negedge clk);
        end
        buf_count = 6'd1; #1;
        check(card_wr_req, "R6 resumes", int'(card_wr_req), 1);
        @(negedge clk); enable = 1'b0; buf_count = '0;
        @(negedge clk); enable = 1'b1;

        // R11 writes while active ignored; R10 abort mid-entry
        cfg(4, 1);
        issue(1'b1);
        len_wr = 1'b1; len_val = 11'd0; cnt_wr = 1'b1; cnt_val = 11'd0;
        @(negedge clk); len_wr = 1'b0; cnt_wr = 1'b0; #1;
        check(bytes_left == 12'd4 && blocks_left == 12'd1, "R11 busy write",
              int'(bytes_left) * 4096 + int'(blocks_left), 4 * 4096 + 1);
        card_rdy = 1'b1; card_rd_data = 8'hEE;
        @(negedge clk); card_rdy = 1'b0; #1;
        check(bytes_left == 12'd3, "R8 one byte taken", int'(bytes_left), 3);
        check(!buf_push, "R3 no early push", int'(buf_push), 0);
        enable = 1'b0;
        @(negedge clk); enable = 1'b1; #1;
        check(!xfer_active && bytes_left == 12'd4, "R10 abort reload", int'(bytes_left), 4);
        check(blocks_left == 12'd1, "R11 count kept", int'(blocks_left), 1);

        // R10 restart by new command drops the half-built entry
        issue(1'b1);
        card_rdy = 1'b1; card_rd_data = 8'hEE;
        @(negedge clk); card_rdy = 1'b0;
        run_rx(4, 1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule